// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block decides when a DRAM controller sends refresh commands. An interval counter produces one tick per programmed refresh period. Each tick adds one unit to a signed refresh debt. Each refresh the block sends removes one unit. A positive debt counts refreshes that have been deferred. A negative debt counts refreshes that were sent ahead of time. The limit on the debt in either direction depends on the selected refresh rate mode.

A refresh goes out in one of two cases. The first is an urgent refresh, when the deferred count has reached its limit. The second is an early refresh, when the controller signals a quiet moment through the idle hint and the early count has room. In both cases the banks must already have reported idle for the programmed precharge time. After a refresh is sent, a blocking flag tells the controller to hold every other command for the refresh cycle time.

The control state machine has three states:
- IDLE: no urgency. IDLE moves to URGENT when the debt sits at its limit and nothing is sent.
- URGENT: a refresh is owed and the block is waiting for the precharge time to be met.
- BLOCK: the refresh cycle time is running down.

Transitions:
- Sending a refresh from IDLE or URGENT leads to BLOCK.
- BLOCK returns to IDLE when its countdown ends.
- URGENT falls back to IDLE only if the debt leaves the limit. This can happen when a mode change raises the limit.

Top module: `refresh_sched`

## Requirements
- R1: After reset the debt is zero, the state is IDLE, and ref_needed, cmd_block and (while banks_idle is low) ref_issue are all low.
- R2: One tick happens every trefi_cycles clock cycles, the first in cycle trefi_cycles-1 after reset. Each tick without a refresh in the same cycle adds one to the debt. The debt saturates at the mode limit.
- R3: refresh_mode selects the limit: 0 gives 8, 1 gives 16, and 2 or 3 give 32. ref_needed is high exactly while the debt is at or above the limit.
- R4: ref_issue is only high in a cycle where banks_idle is high and was also high for at least trp_cycles consecutive cycles before it. A low banks_idle restarts that count.
- R5: When ref_needed is high, the block is not in BLOCK, and R4 is met, ref_issue rises in that same cycle.
- R6: When idle_hint is high, R4 is met, and the debt is above minus the limit, ref_issue rises and the debt drops by one. When the debt equals minus the limit, the hint is ignored.
- R7: cmd_block is high in the cycle of ref_issue and for the next trfc_cycles-1 cycles (trfc_cycles at least 2). No ref_issue occurs while the block is in BLOCK.
- R8: A tick and a ref_issue in the same cycle leave the debt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trefi_cycles | input | TW | Average refresh period in cycles |
| trp_cycles | input | TW | Required idle time before a refresh |
| trfc_cycles | input | TW | Command block time after a refresh |
| refresh_mode | input | 2 | Rate mode: 0 = 1x, 1 = 2x, 2/3 = 4x |
| banks_idle | input | 1 | All banks precharged and idle |
| idle_hint | input | 1 | Controller has a free slot for an early refresh |
| ref_needed | output | 1 | Deferred refreshes at limit; banks must be closed |
| ref_issue | output | 1 | One-cycle strobe: send a refresh now |
| cmd_block | output | 1 | Other commands must not be sent |

## Verification
The assertions check four properties on every cycle:
- a refresh never goes out while the banks are busy or the idle time is unmet;
- every refresh is followed by a blocked cycle;
- an early refresh always coincides with the hint;
- a coinciding tick and refresh leave the debt alone.

Only the bench scenarios show the quantities that depend on history:
- the exact cycle in which urgency arises for each mode;
- the length of the precharge wait and of the block window;
- the number of early refreshes before the lower limit stops them;
- that cancelled tick and refresh pairs leave the debt at zero, which shows up as the exact cycle of the next urgent refresh.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_URGENT = 2'd1,
        ST_BLOCK  = 2'd2
    } rs_state_e;

    // Debt limit per rate mode, scaled from the 1x value.
    function automatic int rs_limit(input logic [1:0] mode, input int base);
        case (mode)
            2'd0:    return base;
            2'd1:    return base * 2;
            default: return base * 4;
        endcase
    endfunction

endpackage

// File: rtl/refsched_tick.sv
module refsched_tick #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] period,
    output logic          tick
);
    logic [TW-1:0] cnt;

    // Compare with >= so a shortened period never skips a wrap.
    assign tick = (cnt >= (period - TW'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + TW'(1);
    end
endmodule

// File: rtl/refsched_prech.sv
module refsched_prech #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          banks_idle,
    input  logic [TW-1:0] trp,
    output logic          rp_ok
);
    logic [TW-1:0] run;

    // Consecutive idle cycles, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          run <= '0;
        else if (!banks_idle) run <= '0;
        else if (run != '1)  run <= run + TW'(1);
    end

    assign rp_ok = banks_idle && (run >= trp);

    AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !banks_idle |=> !rp_ok || (trp == '0)); // R4
endmodule

// File: rtl/refsched_debt.sv
module refsched_debt #(
    parameter int DW = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 issue,
    input  logic signed [DW-1:0] limit,
    output logic                 at_limit,
    output logic                 at_floor
);
    logic signed [DW-1:0] debt, debt_n;

    assign at_limit = (debt >= limit);
    assign at_floor = (debt <= -limit);

    always_comb begin
        debt_n = debt;
        if (tick && !issue && !at_limit) debt_n = debt + DW'(1);
        else if (issue && !tick)         debt_n = debt - DW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) debt <= '0;
        else        debt <= debt_n;
    end

    AST_TICK_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        tick && issue |=> $stable(debt)); // R8
    AST_TICK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !issue && !at_limit |=> debt > $past(debt)); // R2
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsched_pkg::*;
#(
    parameter int TW         = 16,
    parameter int BASE_LIMIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] trefi_cycles,
    input  logic [TW-1:0] trp_cycles,
    input  logic [TW-1:0] trfc_cycles,
    input  logic [1:0]    refresh_mode,
    input  logic          banks_idle,
    input  logic          idle_hint,
    output logic          ref_needed,
    output logic          ref_issue,
    output logic          cmd_block
);
    localparam int MAX_LIM = BASE_LIMIT * 4;
    localparam int DW      = $clog2(MAX_LIM) + 2;

    rs_state_e            state, state_n;
    logic [TW-1:0]        blk_cnt;
    logic signed [DW-1:0] lim;
    logic                 tick, rp_ok, at_limit, at_floor, fire;

    assign lim = DW'(rs_limit(refresh_mode, BASE_LIMIT));

    refsched_tick #(.TW(TW)) u_tick (
        .clk(clk), .rst_n(rst_n), .period(trefi_cycles), .tick(tick)
    );

    refsched_prech #(.TW(TW)) u_prech (
        .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle),
        .trp(trp_cycles), .rp_ok(rp_ok)
    );

    refsched_debt #(.DW(DW)) u_debt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .issue(fire),
        .limit(lim), .at_limit(at_limit), .at_floor(at_floor)
    );

    assign fire = (state != ST_BLOCK) && rp_ok &&
                  (at_limit || (idle_hint && !at_floor));

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE, ST_URGENT: begin
                if (fire)
                    state_n = (trfc_cycles > TW'(1)) ? ST_BLOCK : ST_IDLE;
                else
                    state_n = at_limit ? ST_URGENT : ST_IDLE;
            end
            ST_BLOCK: if (blk_cnt <= TW'(1)) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // State register and block countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            blk_cnt <= '0;
        end else begin
            state <= state_n;
            if (fire)                  blk_cnt <= trfc_cycles - TW'(1);
            else if (state == ST_BLOCK) blk_cnt <= blk_cnt - TW'(1);
        end
    end

    // Outputs
    always_comb begin
        ref_issue  = fire;
        ref_needed = at_limit;
        cmd_block  = fire || (state == ST_BLOCK);
    end

    AST_ISSUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_issue |-> banks_idle); // R4
    AST_BLOCK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ref_issue && (trfc_cycles > TW'(1)) |=> cmd_block && !ref_issue); // R7
    AST_EARLY_HINT: assert property (@(posedge clk) disable iff (!rst_n)
        ref_issue && !ref_needed |-> idle_hint); // R6
    AST_URGENT_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        ref_needed && rp_ok && (state != ST_BLOCK) |-> ref_issue); // R5
endmodule

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] trefi_cycles = 16'd4;
    logic [TW-1:0] trp_cycles = 16'd0;
    logic [TW-1:0] trfc_cycles = 16'd4;
    logic [1:0]    refresh_mode = 2'd0;
    logic          banks_idle = 1'b0;
    logic          idle_hint = 1'b0;
    logic          ref_needed, ref_issue, cmd_block;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    refresh_sched #(.TW(TW), .BASE_LIMIT(8)) u0 (
        .clk(clk), .rst_n(rst_n), .trefi_cycles(trefi_cycles),
        .trp_cycles(trp_cycles), .trfc_cycles(trfc_cycles),
        .refresh_mode(refresh_mode), .banks_idle(banks_idle),
        .idle_hint(idle_hint), .ref_needed(ref_needed),
        .ref_issue(ref_issue), .cmd_block(cmd_block)
    );

    // mode, cycles after reset, expected ref_needed (R3, R2)
    localparam int NV = 8;
    localparam int TV [NV][3] = '{
        '{0, 31, 0}, '{0, 32, 1}, '{1, 63, 0}, '{1, 64, 1},
        '{2, 127, 0}, '{2, 128, 1}, '{3, 127, 0}, '{3, 128, 1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [1:0] m, input int trefi, input int trp,
                            input int trfc, input logic bidle);
        rst_n = 1'b0;
        refresh_mode = m;
        trefi_cycles = TW'(trefi);
        trp_cycles = TW'(trp);
        trfc_cycles = TW'(trfc);
        banks_idle = bidle;
        idle_hint = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        int first;

        // R1: reset state
        do_reset(2'd0, 4, 0, 4, 1'b0);
        #1;
        chk("R1 ref_needed", int'(ref_needed), 0);
        chk("R1 ref_issue", int'(ref_issue), 0);
        chk("R1 cmd_block", int'(cmd_block), 0);

        // R3/R2: limit per mode via vector table
        for (int i = 0; i < NV; i++) begin
            do_reset(2'(TV[i][0]), 4, 0, 4, 1'b0);
            step(TV[i][1]);
            #1;
            chk("R3 ref_needed vs mode", int'(ref_needed), TV[i][2]);
        end

        // R4/R5/R7: urgent refresh waits for tRP, then blocks tRFC
        do_reset(2'd0, 4, 3, 5, 1'b0);
        step(32);                   // cycle 32, debt 8
        trefi_cycles = 16'd1000;
        banks_idle = 1'b1;
        #1;
        chk("R3 urgent raised", int'(ref_needed), 1);
        chk("R4 no issue before tRP", int'(ref_issue), 0);
        step(2);                    // cycle 34
        chk("R4 no issue at tRP-1", int'(ref_issue), 0);
        step(1);                    // cycle 35
        chk("R5 urgent issue", int'(ref_issue), 1);
        chk("R7 block in issue cycle", int'(cmd_block), 1);
        step(1);                    // cycle 36
        chk("R3 need cleared", int'(ref_needed), 0);
        chk("R7 block held", int'(cmd_block), 1);
        step(3);                    // cycle 39
        chk("R7 block last cycle", int'(cmd_block), 1);
        step(1);                    // cycle 40
        chk("R7 block released", int'(cmd_block), 0);

        // R6: early refreshes until debt reaches -8 (from 7: 15 refreshes)
        idle_hint = 1'b1;
        n = 0;
        for (int c = 0; c < 200; c++) begin
            #1;
            if (ref_issue) n++;
            step(1);
        end
        chk("R6 early refresh count", n, 15);
        #1;
        chk("R6 hint ignored at floor", int'(ref_issue), 0);
        chk("R6 no block at floor", int'(cmd_block), 0);

        // R8: ticks and refreshes coinciding leave debt at zero
        do_reset(2'd0, 4, 0, 4, 1'b1);
        step(3);                    // cycle 3
        idle_hint = 1'b1;
        n = 0;
        for (int c = 0; c < 80; c++) begin
            #1;
            if (ref_issue) n++;
            step(1);
        end
        chk("R8 aligned refresh count", n, 20);
        idle_hint = 1'b0;           // cycle 83
        first = -1;
        for (int c = 0; c < 60; c++) begin
            #1;
            if (ref_issue && first < 0) first = c;
            step(1);
        end
        chk("R8 debt stayed zero (urgent offset)", first, 29);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule